// File: doc/BRIEF.md
# MDIO Management Master Controller

This block is a bus-attached master for the two-wire station management interface used to configure Ethernet PHYs. Software first places a 16-bit payload in the outgoing data register. It then writes a command word that holds the PHY port address, the register or device address and a two-bit opcode. The controller builds the management frame and shifts it out on MDIO, timed by an MDC clock that it generates itself. Reads return the 16 bits captured from the PHY in a result register.

A mode bit selects between the classic 22-style framing and the extended 45-style framing. The meaning of the opcode field depends on that bit. Completion is not reported through a status register. Instead, a busy flag sits in the outgoing data register for writes and address frames, and a busy flag plus a valid flag sit in the result register for reads. An optional 32-bit preamble of ones, the MDC divisor and a global enable complete the configuration.

The frame engine is a state machine with six states:

| State | What it does | Leaves when |
|---|---|---|
| ST_IDLE | Waits for an accepted command | A command is accepted: to ST_PREAMBLE if the preamble is on, otherwise to ST_HEADER |
| ST_PREAMBLE | Sends 32 ones | The 32nd MDC fall: to ST_HEADER |
| ST_HEADER | Sends start, opcode, port and register fields (14 bits) | The 14th MDC fall: to ST_TURN |
| ST_TURN | Two turnaround slots | The 2nd MDC fall: to ST_DATA |
| ST_DATA | Moves the 16 payload bits | The 16th MDC fall: to ST_DONE |
| ST_DONE | One cycle that reports completion to the registers | Next cycle: to ST_IDLE |

From any active state, clearing the enable sends the machine to ST_IDLE (abort).

Top module: `mdio_ctrl`

## Requirements
- R1: After reset, registers read as: command (0x00) = 0, outgoing data (0x08) = 0, result (0x10) = 0, configuration (0x18) = 8 (divisor), enable (0x20) = 0. MDC is low and MDIO is not driven. A read returns the addressed register on `bus_rdata` one cycle after `bus_rd`.
- R2: In 22-style mode (configuration bit 24 = 0), a command (register address in bits 4:0, port address in bits 12:8, opcode in bits 17:16) with opcode 0 sends a write frame. The frame is start 01, opcode 01, port address, register address, turnaround 10, then bits 15:0 of the outgoing data register, each field MSB first. Every bit is launched on an MDC falling edge and MDIO is held steady while MDC is high.
- R3: In 22-style mode, opcode 1 sends start 01 and opcode 10. MDIO is released for both turnaround slots and all 16 data slots. Data is sampled on rising MDC edges. The result register then reads bit 16 = 1 with the data in bits 15:0.
- R4: In 45-style mode (bit 24 = 1), the start code is 00. Opcode 0 sends an address frame (wire opcode 00), opcode 1 a write (01) and opcode 3 a read (11). Address and write frames carry the outgoing data payload, and reads behave as in R3.
- R5: With configuration bit 12 set, each frame begins with 32 MDC periods of MDIO driven to 1. With it clear, the start code comes first.
- R6: Bit 17 of the outgoing data register is 1 while a write or address frame is in flight. Bit 17 of the result register is 1 while a read is in flight. At most one is set, and each returns to 0 when its frame ends.
- R7: Accepting a read clears result bit 16 until that read completes. The valid flag and the read busy flag are never both set.
- R8: A command written while either busy flag is set is dropped. No second frame follows, and the result register is left unchanged.
- R9: While enable bit 0 is 0, command writes are ignored and are not latched (a read of the command register returns the last accepted command), and MDIO is not driven. Clearing the enable during a frame stops it, releases MDIO, returns MDC low and clears the busy flag.
- R10: The MDC period equals the even divisor held in configuration bits 7:0 (a value below 2 acts as 2), in system clocks, with a 50 % duty cycle. MDC stays low between frames.
- R11: Undefined opcodes (2 and 3 in 22-style mode, 2 in 45-style mode) start no frame and set no busy flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Register byte address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Read data, valid the cycle after `bus_rd` |
| mdc | output | 1 | Management clock to the PHYs |
| mdio_i | input | 1 | MDIO value seen at the pad |
| mdio_o | output | 1 | MDIO value to drive |
| mdio_oe | output | 1 | MDIO drive enable |

## Verification
The hardest situations to reach are register accesses that land while a frame is already on the wire: a second command arriving mid-frame, a busy flag read just after issue, and the enable dropping partway through. The bench uses one per-cycle loop that both watches MDC/MDIO and drives the register bus. In that loop it issues a status read in the first cycles of each frame and injects a competing command two cycles after issue. A separate directed test clears the enable after about thirty cycles of a preamble. The same loop acts as the PHY, presenting response bits after the correct count of MDC falling edges, so that read capture timing is checked against the wire and not against the controller's internals.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int REG_W     = 64;
    localparam int PAY_W     = 16;
    localparam int FLD_W     = 5;
    localparam int PRE_BITS  = 32;
    localparam int HDR_BITS  = 2 + 2 + FLD_W + FLD_W;
    localparam int TA_BITS   = 2;
    localparam int FRAME_W   = HDR_BITS + TA_BITS + PAY_W;

    // register byte offsets
    localparam int OFF_CMD   = 'h00;
    localparam int OFF_WDATA = 'h08;
    localparam int OFF_RDATA = 'h10;
    localparam int OFF_CFG   = 'h18;
    localparam int OFF_EN    = 'h20;

    // field positions
    localparam int RA_LSB    = 0;
    localparam int PA_LSB    = 8;
    localparam int OP_LSB    = 16;
    localparam int BIT_BUSY  = 17;
    localparam int BIT_VALID = 16;
    localparam int BIT_MODE  = 24;
    localparam int BIT_PRE   = 12;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PREAMBLE,
        ST_HEADER,
        ST_TURN,
        ST_DATA,
        ST_DONE
    } mdio_state_e;

    typedef struct packed {
        logic       legal;
        logic       is_read;
        logic [1:0] st;
        logic [1:0] wire_op;
    } mdio_op_t;

    function automatic mdio_op_t decode_op(input logic c45, input logic [1:0] op);
        mdio_op_t r;
        r.legal   = 1'b0;
        r.is_read = 1'b0;
        r.st      = c45 ? 2'b00 : 2'b01;
        r.wire_op = 2'b00;
        if (!c45) begin
            case (op)
                2'd0:    begin r.legal = 1'b1; r.wire_op = 2'b01; end
                2'd1:    begin r.legal = 1'b1; r.is_read = 1'b1; r.wire_op = 2'b10; end
                default: r.legal = 1'b0;
            endcase
        end else begin
            case (op)
                2'd0:    begin r.legal = 1'b1; r.wire_op = 2'b00; end
                2'd1:    begin r.legal = 1'b1; r.wire_op = 2'b01; end
                2'd3:    begin r.legal = 1'b1; r.is_read = 1'b1; r.wire_op = 2'b11; end
                default: r.legal = 1'b0;
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             mdc,
    output logic             rise_tick,
    output logic             fall_tick
);

    localparam int HW = DIV_W - 1;

    logic [HW-1:0] half;
    logic [HW-1:0] cnt_q;
    logic          mdc_q;
    logic          edge_now;

    always_comb begin
        half = div[DIV_W-1:1];
        if (half == '0) half = HW'(1);
    end

    assign edge_now  = run && (cnt_q >= half - 1'b1);
    assign rise_tick = edge_now && !mdc_q;
    assign fall_tick = edge_now && mdc_q;
    assign mdc       = mdc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            mdc_q <= 1'b0;
        end else if (!run) begin
            cnt_q <= '0;
            mdc_q <= 1'b0;
        end else if (edge_now) begin
            cnt_q <= '0;
            mdc_q <= ~mdc_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/mdio_frame_fsm.sv
module mdio_frame_fsm
    import mdio_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en,
    input  logic                start,
    input  logic                is_read,
    input  logic                pre_en,
    input  logic [HDR_BITS-1:0] hdr,
    input  logic [PAY_W-1:0]    payload,
    input  logic                rise_tick,
    input  logic                fall_tick,
    input  logic                mdio_i,
    output logic                run,
    output logic                mdio_o,
    output logic                mdio_oe,
    output logic                done,
    output logic [PAY_W-1:0]    rd_data
);

    localparam int CNT_W = $clog2(PRE_BITS + 1);

    mdio_state_e          state_q, state_d;
    logic [CNT_W-1:0]     cnt_q;
    logic [FRAME_W-1:0]   frame_q;
    logic [PAY_W-1:0]     rd_q;
    logic                 read_q;
    logic                 last_slot;

    always_comb begin
        unique case (state_q)
            ST_PREAMBLE: last_slot = (cnt_q == CNT_W'(PRE_BITS - 1));
            ST_HEADER:   last_slot = (cnt_q == CNT_W'(HDR_BITS - 1));
            ST_TURN:     last_slot = (cnt_q == CNT_W'(TA_BITS - 1));
            ST_DATA:     last_slot = (cnt_q == CNT_W'(PAY_W - 1));
            default:     last_slot = 1'b0;
        endcase
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (start && en) state_d = pre_en ? ST_PREAMBLE : ST_HEADER;
            ST_PREAMBLE: if (fall_tick && last_slot) state_d = ST_HEADER;
            ST_HEADER:   if (fall_tick && last_slot) state_d = ST_TURN;
            ST_TURN:     if (fall_tick && last_slot) state_d = ST_DATA;
            ST_DATA:     if (fall_tick && last_slot) state_d = ST_DONE;
            ST_DONE:     state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
        if (!en && state_q != ST_IDLE) state_d = ST_IDLE;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            frame_q <= '0;
            rd_q    <= '0;
            read_q  <= 1'b0;
        end else begin
            if (state_d != state_q)  cnt_q <= '0;
            else if (fall_tick)      cnt_q <= cnt_q + 1'b1;

            if (state_q == ST_IDLE && start && en) begin
                frame_q <= {hdr, 2'b10, payload};
                read_q  <= is_read;
            end else if (fall_tick && (state_q == ST_HEADER || state_q == ST_TURN ||
                                       state_q == ST_DATA)) begin
                frame_q <= {frame_q[FRAME_W-2:0], 1'b0};
            end

            if (rise_tick && state_q == ST_DATA) rd_q <= {rd_q[PAY_W-2:0], mdio_i};
        end
    end

    // outputs
    always_comb begin
        run     = 1'b0;
        mdio_oe = 1'b0;
        mdio_o  = 1'b0;
        done    = 1'b0;
        unique case (state_q)
            ST_IDLE:     ;
            ST_PREAMBLE: begin run = 1'b1; mdio_oe = en; mdio_o = en; end
            ST_HEADER:   begin run = 1'b1; mdio_oe = en; mdio_o = en && frame_q[FRAME_W-1]; end
            ST_TURN,
            ST_DATA:     begin
                run     = 1'b1;
                mdio_oe = en && !read_q;
                mdio_o  = en && !read_q && frame_q[FRAME_W-1];
            end
            ST_DONE:     done = 1'b1;
            default:     ;
        endcase
    end

    assign rd_data = rd_q;

endmodule

// File: rtl/mdio_regfile.sv
module mdio_regfile
    import mdio_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int DIV_W     = 8,
    parameter int DIV_RESET = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [REG_W-1:0]    bus_wdata,
    output logic [REG_W-1:0]    bus_rdata,
    input  logic                fsm_done,
    input  logic [PAY_W-1:0]    fsm_rd_data,
    output logic                start,
    output logic                start_read,
    output logic [HDR_BITS-1:0] hdr,
    output logic [PAY_W-1:0]    payload,
    output logic                pre_en,
    output logic [DIV_W-1:0]    div,
    output logic                en,
    output logic                wr_pend,
    output logic                rd_pend,
    output logic                rd_valid
);

    localparam logic [ADDR_W-1:0] A_CMD   = ADDR_W'(OFF_CMD);
    localparam logic [ADDR_W-1:0] A_WDATA = ADDR_W'(OFF_WDATA);
    localparam logic [ADDR_W-1:0] A_RDATA = ADDR_W'(OFF_RDATA);
    localparam logic [ADDR_W-1:0] A_CFG   = ADDR_W'(OFF_CFG);
    localparam logic [ADDR_W-1:0] A_EN    = ADDR_W'(OFF_EN);

    logic [FLD_W-1:0]  ra_q, pa_q;
    logic [1:0]        op_q;
    logic [PAY_W-1:0]  wdat_q, rdat_q;
    logic              c45_q, pre_q, en_q;
    logic [DIV_W-1:0]  div_q;
    logic              wpend_q, rpend_q, valid_q;
    logic              start_q, start_rd_q;
    logic [HDR_BITS-1:0] hdr_q;
    logic [REG_W-1:0]  rd_mux;
    logic [FLD_W-1:0]  cmd_ra, cmd_pa;
    logic              accept;
    mdio_op_t          dec;

    assign cmd_ra = bus_wdata[RA_LSB +: FLD_W];
    assign cmd_pa = bus_wdata[PA_LSB +: FLD_W];

    always_comb dec = decode_op(c45_q, bus_wdata[OP_LSB +: 2]);

    assign accept = bus_wr && (bus_addr == A_CMD) && en_q && !wpend_q && !rpend_q && dec.legal;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ra_q       <= '0;
            pa_q       <= '0;
            op_q       <= '0;
            wdat_q     <= '0;
            rdat_q     <= '0;
            c45_q      <= 1'b0;
            pre_q      <= 1'b0;
            en_q       <= 1'b0;
            div_q      <= DIV_W'(DIV_RESET);
            wpend_q    <= 1'b0;
            rpend_q    <= 1'b0;
            valid_q    <= 1'b0;
            start_q    <= 1'b0;
            start_rd_q <= 1'b0;
            hdr_q      <= '0;
        end else begin
            start_q <= accept;
            if (bus_wr && bus_addr == A_WDATA) wdat_q <= bus_wdata[PAY_W-1:0];
            if (bus_wr && bus_addr == A_EN)    en_q   <= bus_wdata[0];
            if (bus_wr && bus_addr == A_CFG) begin
                div_q <= bus_wdata[DIV_W-1:0];
                pre_q <= bus_wdata[BIT_PRE];
                c45_q <= bus_wdata[BIT_MODE];
            end
            if (fsm_done) begin
                if (rpend_q) begin
                    valid_q <= 1'b1;
                    rdat_q  <= fsm_rd_data;
                end
                wpend_q <= 1'b0;
                rpend_q <= 1'b0;
            end
            if (!en_q) begin
                wpend_q <= 1'b0;
                rpend_q <= 1'b0;
            end
            if (accept) begin
                ra_q       <= cmd_ra;
                pa_q       <= cmd_pa;
                op_q       <= bus_wdata[OP_LSB +: 2];
                hdr_q      <= {dec.st, dec.wire_op, cmd_pa, cmd_ra};
                start_rd_q <= dec.is_read;
                wpend_q    <= !dec.is_read;
                rpend_q    <= dec.is_read;
                if (dec.is_read) valid_q <= 1'b0;
            end
        end
    end

    always_comb begin
        rd_mux = '0;
        unique case (bus_addr)
            A_CMD: begin
                rd_mux[RA_LSB +: FLD_W] = ra_q;
                rd_mux[PA_LSB +: FLD_W] = pa_q;
                rd_mux[OP_LSB +: 2]     = op_q;
            end
            A_WDATA: begin
                rd_mux[PAY_W-1:0] = wdat_q;
                rd_mux[BIT_BUSY]  = wpend_q;
            end
            A_RDATA: begin
                rd_mux[PAY_W-1:0] = rdat_q;
                rd_mux[BIT_VALID] = valid_q;
                rd_mux[BIT_BUSY]  = rpend_q;
            end
            A_CFG: begin
                rd_mux[DIV_W-1:0] = div_q;
                rd_mux[BIT_PRE]   = pre_q;
                rd_mux[BIT_MODE]  = c45_q;
            end
            A_EN:    rd_mux[0] = en_q;
            default: rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_mux;
    end

    assign start      = start_q;
    assign start_read = start_rd_q;
    assign hdr        = hdr_q;
    assign payload    = wdat_q;
    assign pre_en     = pre_q;
    assign div        = div_q;
    assign en         = en_q;
    assign wr_pend    = wpend_q;
    assign rd_pend    = rpend_q;
    assign rd_valid   = valid_q;

endmodule

// File: rtl/mdio_ctrl.sv
module mdio_ctrl
    import mdio_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int DIV_W     = 8,
    parameter int DIV_RESET = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    output logic              mdc,
    input  logic              mdio_i,
    output logic              mdio_o,
    output logic              mdio_oe
);

    logic                start, start_read, pre_en, en;
    logic                wr_pend, rd_pend, rd_valid;
    logic                run, rise_tick, fall_tick, done;
    logic [HDR_BITS-1:0] hdr;
    logic [PAY_W-1:0]    payload, rd_data;
    logic [DIV_W-1:0]    div;

    mdio_regfile #(
        .ADDR_W    (ADDR_W),
        .DIV_W     (DIV_W),
        .DIV_RESET (DIV_RESET)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_addr    (bus_addr),
        .bus_wr      (bus_wr),
        .bus_rd      (bus_rd),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .fsm_done    (done),
        .fsm_rd_data (rd_data),
        .start       (start),
        .start_read  (start_read),
        .hdr         (hdr),
        .payload     (payload),
        .pre_en      (pre_en),
        .div         (div),
        .en          (en),
        .wr_pend     (wr_pend),
        .rd_pend     (rd_pend),
        .rd_valid    (rd_valid)
    );

    mdio_mdc_gen #(.DIV_W(DIV_W)) u_mdc (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .div       (div),
        .mdc       (mdc),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    mdio_frame_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .start     (start),
        .is_read   (start_read),
        .pre_en    (pre_en),
        .hdr       (hdr),
        .payload   (payload),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick),
        .mdio_i    (mdio_i),
        .run       (run),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .done      (done),
        .rd_data   (rd_data)
    );

endmodule

// File: rtl/mdio_ctrl_chk.sv
module mdio_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic mdc,
    input logic mdio_o,
    input logic mdio_oe,
    input logic en,
    input logic wr_pend,
    input logic rd_pend,
    input logic rd_valid
);

    assert_tristate_when_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !mdio_oe);

    assert_single_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_pend, rd_pend}));

    assert_valid_cleared_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_pend |-> !rd_valid);

    assert_mdc_idle_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_pend && !rd_pend && !$past(wr_pend) && !$past(rd_pend)) |-> !mdc);

    assert_steady_while_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en) && mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));

endmodule

bind mdio_ctrl mdio_ctrl_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mdc      (mdc),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe),
    .en       (en),
    .wr_pend  (wr_pend),
    .rd_pend  (rd_pend),
    .rd_valid (rd_valid)
);

// File: tb/mdio_ctrl_tb.sv
`timescale 1ns/1ps
module mdio_ctrl_tb;

    localparam logic [7:0] A_CMD = 8'h00, A_WD = 8'h08, A_RD = 8'h10, A_CFG = 8'h18, A_EN = 8'h20;

    typedef struct packed {
        logic        c45;
        logic        pre;
        logic [1:0]  op;
        logic [4:0]  phy;
        logic [4:0]  ra;
        logic [15:0] d;
        logic [3:0]  div;
        logic        inj;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 2'd0, 5'h03, 5'h11, 16'hA5C3, 4'd4, 1'b0},
        '{1'b0, 1'b1, 2'd1, 5'h1F, 5'h00, 16'h1234, 4'd6, 1'b0},
        '{1'b1, 1'b0, 2'd0, 5'h02, 5'h07, 16'h0400, 4'd4, 1'b0},
        '{1'b1, 1'b1, 2'd1, 5'h0A, 5'h01, 16'hFFFF, 4'd8, 1'b1},
        '{1'b1, 1'b0, 2'd3, 5'h15, 5'h1E, 16'h8001, 4'd4, 1'b0},
        '{1'b0, 1'b0, 2'd1, 5'h00, 5'h1F, 16'h0F0F, 4'd2, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  addr = '0;
    logic        wr = 1'b0;
    logic        rd = 1'b0;
    logic [63:0] wdata = '0;
    logic [63:0] rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    int n_checks = 0;
    int n_fail   = 0;
    logic [15:0] last_resp = '0;

    always #10 clk = ~clk;

    mdio_ctrl u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (addr),
        .bus_wr    (wr),
        .bus_rd    (rd),
        .bus_wdata (wdata),
        .bus_rdata (rdata),
        .mdc       (mdc),
        .mdio_i    (mdio_i),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [7:0] a, input logic [63:0] d);
        @(negedge clk); addr = a; wdata = d; wr = 1'b1;
        @(negedge clk); wr = 1'b0;
    endtask

    task automatic reg_rd(input logic [7:0] a, output logic [63:0] d);
        @(negedge clk); addr = a; rd = 1'b1;
        @(negedge clk); rd = 1'b0; d = rdata;
    endtask

    function automatic logic [63:0] cmd_word(input logic [1:0] op, input logic [4:0] phy, input logic [4:0] ra);
        return (64'(op) << 16) | (64'(phy) << 8) | 64'(ra);
    endfunction

    // expected wire bits, built from R2..R5 encodings
    task automatic build_exp(input vec_t v, output logic [63:0] eo, output logic [63:0] eoe, output int n);
        logic [13:0] hdr;
        logic [1:0]  st, opw;
        logic        rdk;
        eo = '0; eoe = '0; n = 0;
        rdk = v.c45 ? (v.op == 2'd3) : (v.op == 2'd1);
        st  = v.c45 ? 2'b00 : 2'b01;
        if (v.c45) opw = (v.op == 2'd0) ? 2'b00 : (v.op == 2'd1) ? 2'b01 : 2'b11;
        else       opw = (v.op == 2'd0) ? 2'b01 : 2'b10;
        hdr = {st, opw, v.phy, v.ra};
        if (v.pre) for (int i = 0; i < 32; i++) begin
            eo = {eo[62:0], 1'b1}; eoe = {eoe[62:0], 1'b1}; n++;
        end
        for (int i = 13; i >= 0; i--) begin
            eo = {eo[62:0], hdr[i]}; eoe = {eoe[62:0], 1'b1}; n++;
        end
        for (int i = 1; i >= 0; i--) begin
            eo = {eo[62:0], rdk ? 1'b0 : (i == 1)}; eoe = {eoe[62:0], !rdk}; n++;
        end
        for (int i = 15; i >= 0; i--) begin
            eo = {eo[62:0], rdk ? 1'b0 : v.d[i]}; eoe = {eoe[62:0], !rdk}; n++;
        end
    endtask

    task automatic run_vec(input vec_t v);
        logic [63:0] eo, eoe, cap_o, cap_oe, r;
        int   n, ncap, falls, cyc, last_rise, last_fall_high, bad_per, budget, p;
        logic prev, rdk;
        string tag;
        rdk = v.c45 ? (v.op == 2'd3) : (v.op == 2'd1);
        tag = v.c45 ? "R4" : (rdk ? "R3" : "R2");
        p   = v.pre ? 32 : 0;
        build_exp(v, eo, eoe, n);
        reg_wr(A_CFG, (64'(v.c45) << 24) | (64'(v.pre) << 12) | 64'(v.div));
        reg_wr(A_WD, 64'(v.d));
        mdio_i = 1'b1;
        reg_wr(A_CMD, cmd_word(v.op, v.phy, v.ra));
        cap_o = '0; cap_oe = '0; ncap = 0; falls = 0; cyc = 0;
        last_rise = -1; last_fall_high = -1; bad_per = 0; prev = 1'b0;
        budget = n * int'(v.div) + 40;
        for (int k = 0; k < budget; k++) begin
            if (k == 0) begin addr = rdk ? A_RD : A_WD; rd = 1'b1; end
            if (k == 1) begin
                rd = 1'b0;
                check(rdata[17] == 1'b1, "R6 busy flag during frame", rdata, 64'h20000);
                if (rdk) check(rdata[16] == 1'b0, "R7 valid cleared by new read", rdata, 64'h0);
            end
            if (v.inj && k == 2) begin addr = A_CMD; wdata = 64'h0003_0101; wr = 1'b1; end
            if (v.inj && k == 3) wr = 1'b0;
            if (mdc && !prev) begin
                cap_o  = {cap_o[62:0], mdio_o};
                cap_oe = {cap_oe[62:0], mdio_oe};
                ncap++;
                if (last_rise >= 0 && (cyc - last_rise) != int'(v.div)) bad_per++;
                last_rise = cyc;
            end
            if (!mdc && prev) begin
                falls++;
                if ((cyc - last_rise) != int'(v.div) / 2) bad_per++;
                if (rdk && falls >= p + 16 && falls < p + 32) mdio_i = v.d[15 - (falls - p - 16)];
                else mdio_i = 1'b1;
            end
            prev = mdc;
            cyc++;
            @(negedge clk);
        end
        check(ncap == n, "R5 MDC period count per frame", 64'(ncap), 64'(n));
        check(cap_oe == eoe, {tag, " drive enable pattern"}, cap_oe, eoe);
        check((cap_o & eoe) == (eo & eoe), {tag, " driven bits"}, cap_o & eoe, eo & eoe);
        check(bad_per == 0, "R10 MDC period and duty", 64'(bad_per), 64'h0);
        check(mdc == 1'b0, "R10 MDC low after frame", 64'(mdc), 64'h0);
        reg_rd(rdk ? A_RD : A_WD, r);
        check(r[17] == 1'b0, "R6 busy flag cleared", r, 64'h0);
        if (rdk) begin
            check(r == ((64'h1 << 16) | 64'(v.d)), {tag, " read result and valid"}, r, (64'h1 << 16) | 64'(v.d));
            last_resp = v.d;
        end
        if (v.inj) begin
            reg_rd(A_RD, r);
            check(r == ((64'h1 << 16) | 64'(last_resp)), "R8 dropped command left result", r,
                  (64'h1 << 16) | 64'(last_resp));
        end
    endtask

    task automatic quiet_window(input string req, input int cycles);
        int bad;
        bad = 0;
        for (int k = 0; k < cycles; k++) begin
            @(negedge clk);
            if (mdc || mdio_oe) bad++;
        end
        check(bad == 0, req, 64'(bad), 64'h0);
    endtask

    task automatic run_all();
        logic [63:0] r;
        // R1 reset state
        check(mdc == 1'b0 && mdio_oe == 1'b0, "R1 pins at reset", {mdc, mdio_oe}, 64'h0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        reg_rd(A_CMD, r); check(r == 64'h0, "R1 command reset", r, 64'h0);
        reg_rd(A_WD, r);  check(r == 64'h0, "R1 outgoing data reset", r, 64'h0);
        reg_rd(A_RD, r);  check(r == 64'h0, "R1 result reset", r, 64'h0);
        reg_rd(A_CFG, r); check(r == 64'h8, "R1 configuration reset", r, 64'h8);
        reg_rd(A_EN, r);  check(r == 64'h0, "R1 enable reset", r, 64'h0);

        reg_wr(A_EN, 64'h1);
        for (int i = 0; i < NV; i++) run_vec(VECS[i]);

        // R9: command while disabled
        reg_wr(A_EN, 64'h0);
        reg_wr(A_CFG, 64'h4);
        reg_wr(A_CMD, cmd_word(2'd0, 5'h07, 5'h05));
        quiet_window("R9 no frame while disabled", 60);
        reg_rd(A_WD, r);  check(r[17] == 1'b0, "R9 no busy while disabled", r, 64'h0);
        reg_rd(A_CMD, r);
        check(r == cmd_word(VECS[5].op, VECS[5].phy, VECS[5].ra), "R9 command not latched", r,
              cmd_word(VECS[5].op, VECS[5].phy, VECS[5].ra));
        reg_wr(A_EN, 64'h1);

        // R11: undefined opcodes
        reg_wr(A_CMD, cmd_word(2'd2, 5'h01, 5'h01));
        quiet_window("R11 22-style opcode 2 ignored", 40);
        reg_wr(A_CMD, cmd_word(2'd3, 5'h01, 5'h01));
        quiet_window("R11 22-style opcode 3 ignored", 40);
        reg_wr(A_CFG, (64'h1 << 24) | 64'h4);
        reg_wr(A_CMD, cmd_word(2'd2, 5'h01, 5'h01));
        quiet_window("R11 45-style opcode 2 ignored", 40);
        reg_rd(A_WD, r); check(r[17] == 1'b0, "R11 no write busy", r, 64'h0);
        reg_rd(A_RD, r); check(r[17] == 1'b0, "R11 no read busy", r, 64'h0);

        // R9: disable mid-frame
        reg_wr(A_CFG, (64'h1 << 12) | 64'h4);
        reg_wr(A_WD, 64'h00FF);
        reg_wr(A_CMD, cmd_word(2'd0, 5'h02, 5'h03));
        repeat (30) @(negedge clk);
        check(mdio_oe == 1'b1, "R5 preamble driving", 64'(mdio_oe), 64'h1);
        reg_wr(A_EN, 64'h0);
        repeat (2) @(negedge clk);
        check(mdio_oe == 1'b0, "R9 released after disable", 64'(mdio_oe), 64'h0);
        repeat (3) @(negedge clk);
        check(mdc == 1'b0, "R9 MDC low after abort", 64'(mdc), 64'h0);
        reg_rd(A_WD, r); check(r == 64'h00FF, "R9 busy cleared by abort", r, 64'h00FF);
        reg_wr(A_EN, 64'h1);
        repeat (5) @(negedge clk);
    endtask

    initial begin
        bit timed_out;
        timed_out = 1'b0;
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                timed_out = 1'b1;
            end
        join_any
        disable fork;
        if (timed_out) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=expired expected=finished");
        end
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule